// File: doc/BRIEF.md
# Register-List Transfer Sequencer

This block moves a set of registers between a register file and word-addressed memory, one 32-bit word per memory handshake. An 8-bit list mask picks registers 0 to 7, where bit i selects register i. A command also carries an op code, a base register index and an extra-slot flag. For a push the extra slot is the link register. For a pop it is the program counter.

The block reads register values through a combinational read port and writes loaded words through a write port. When the transfers are done it updates the base register or the stack pointer through a separate writeback port. It then raises a one-cycle done pulse. Register indices on the ports are 4 bits wide: 0 to 7 are the low registers, 13 is the stack pointer, 14 is the link register and 15 is the program counter. The number of words moved stays on `xfer_count_o`, so a caller can charge wait cycles for that count.

Op codes are 0 for increment-after load, 1 for increment-after store, 2 for push and 3 for pop.

Top module: `rl_seq`

## Requirements
- R1: Op 0 loads the listed registers in ascending register order. It starts at the base register value and adds 4 after each word. The extra flag is ignored by ops 0 and 1.
- R2: After op 0 the base register receives the final address, unless the base is itself in the list. In that case the base keeps the loaded word and no writeback is issued.
- R3: Op 1 stores the listed registers in ascending order from the base value, adding 4 after each word. Each stored word is the register's value before the command. The base always receives the final address.
- R4: Op 2 starts at SP-4 and steps down by 4 for each word. It stores the link register first when the extra flag is set, then registers 7 down to 0.
- R5: After op 2, SP (index 13) holds the lowest address written, or its old value if nothing was written.
- R6: Op 3 loads registers 0 to 7 in ascending order from SP upward. With the extra flag set, one further word goes to index 15 with bit 0 cleared, and `pc_load_o` is high for that write. SP then ends just past the last word read.
- R7: `xfer_count_o` equals the number of words moved by the latest command and holds until the next command.
- R8: A transfer completes only in a cycle where `mem_ready_i` is high. While waiting, the strobe, the address and the register read index stay unchanged.
- R9: `done_o` is high for exactly one cycle, the cycle after the writeback cycle.
- R10: An empty list with no extra slot makes no memory access, gives a count of 0, and writes the unchanged address back.
- R11: A command is accepted only when the block is idle. While `busy_o` is high, `cmd_valid_i` has no effect.
- R12: The read and write strobes are never high together. The write data is the value of the register being stored.
- R13: After reset the block is idle: busy, done, both strobes and the count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request, taken only when idle |
| cmd_op_i | input | 2 | 0 load-increment, 1 store-increment, 2 push, 3 pop |
| cmd_base_i | input | 3 | Base register index for ops 0 and 1 |
| cmd_list_i | input | 8 | Register list mask, bit i selects register i |
| cmd_extra_i | input | 1 | Add link register (push) or program counter (pop) |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| xfer_count_o | output | 4 | Words moved by the latest command |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_ready_i | input | 1 | Memory completes the current transfer |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data, same cycle |
| rf_we_o | output | 1 | Register write enable for loaded words |
| rf_waddr_o | output | 4 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| pc_load_o | output | 1 | The current register write targets the program counter |
| wb_we_o | output | 1 | Base or stack pointer writeback enable |
| wb_addr_o | output | 4 | Writeback register index |
| wb_data_o | output | 32 | Writeback address value |

## Verification
The properties rely on three things about the inputs. The register file answers a read in the same cycle. Memory returns read data in the same cycle in which it raises ready. Ready is only considered while a strobe is high. The bench memory and register models are both combinational on the read side. Ready is driven only after a fixed number of stall cycles into an active strobe, and every address stays inside a 64-word window. New commands are started only when the block is idle, except for one deliberate request during a busy interval that checks R11.

// File: rtl/rl_pkg.sv
`timescale 1ns/1ps
package rl_pkg;
  typedef enum logic [1:0] {
    OP_LDM  = 2'd0,
    OP_STM  = 2'd1,
    OP_PUSH = 2'd2,
    OP_POP  = 2'd3
  } rl_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_XFER,
    ST_WB,
    ST_DONE
  } rl_state_e;

  localparam logic [3:0] REG_SP = 4'd13;
  localparam logic [3:0] REG_LR = 4'd14;
  localparam logic [3:0] REG_PC = 4'd15;
endpackage

// File: rtl/rl_pick.sv
`timescale 1ns/1ps
// Picks the lowest set slot, or the highest when desc_i is set.
module rl_pick #(
  parameter int N  = 9,
  parameter int IW = 4
) (
  input  logic [N-1:0]  mask_i,
  input  logic          desc_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = |mask_i;
    if (desc_i) begin
      for (int i = 0; i < N; i++)
        if (mask_i[i]) idx_o = IW'(i);
    end else begin
      for (int i = N - 1; i >= 0; i--)
        if (mask_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/rl_addr.sv
`timescale 1ns/1ps
module rl_addr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          down_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] addr_up_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (step_i) addr_q <= down_i ? addr_q - AW'(STEP) : addr_q + AW'(STEP);
  end

  assign addr_o    = addr_q;
  assign addr_up_o = addr_q + AW'(STEP);
endmodule

// File: rtl/rl_seq.sv
`timescale 1ns/1ps
module rl_seq
  import rl_pkg::*;
#(
  parameter int  DW     = 32,
  parameter int  LIST_W = 8,
  parameter int  RIDX_W = 4,
  localparam int BASE_W = $clog2(LIST_W),
  localparam int CNT_W  = $clog2(LIST_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [BASE_W-1:0] cmd_base_i,
  input  logic [LIST_W-1:0] cmd_list_i,
  input  logic              cmd_extra_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  xfer_count_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  input  logic              mem_ready_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [RIDX_W-1:0] rf_raddr_o,
  input  logic [DW-1:0]     rf_rdata_i,
  output logic              rf_we_o,
  output logic [RIDX_W-1:0] rf_waddr_o,
  output logic [DW-1:0]     rf_wdata_o,
  output logic              pc_load_o,
  output logic              wb_we_o,
  output logic [RIDX_W-1:0] wb_addr_o,
  output logic [DW-1:0]     wb_data_o
);
  localparam int SLOT_N = LIST_W + 1;   // list bits plus the extra slot on top
  localparam int PICK_W = $clog2(SLOT_N);
  localparam int STEP   = DW / 8;
  localparam logic [RIDX_W-1:0] IDX_SP = RIDX_W'(REG_SP);
  localparam logic [RIDX_W-1:0] IDX_LR = RIDX_W'(REG_LR);
  localparam logic [RIDX_W-1:0] IDX_PC = RIDX_W'(REG_PC);

  rl_state_e          state_q, state_d;
  rl_op_e             op_q;
  logic [RIDX_W-1:0]  base_q;
  logic [SLOT_N-1:0]  pend_q;
  logic               base_hit_q;
  logic [CNT_W-1:0]   cnt_q;

  logic [PICK_W-1:0]  pick_idx;
  logic               pick_vld;
  logic [RIDX_W-1:0]  slot_reg;
  logic               is_load, is_push, stack_op;
  logic               xfer_act, hand;
  logic [DW-1:0]      addr_q, addr_up, start_addr;

  assign is_load  = (op_q == OP_LDM) || (op_q == OP_POP);
  assign is_push  = (op_q == OP_PUSH);
  assign stack_op = (cmd_op_i == OP_PUSH) || (cmd_op_i == OP_POP);

  // push walks downward so its extra slot (link register) goes first
  rl_pick #(.N(SLOT_N), .IW(PICK_W)) u_pick (
    .mask_i (pend_q),
    .desc_i (is_push),
    .idx_o  (pick_idx),
    .valid_o(pick_vld)
  );

  assign start_addr = is_push ? rf_rdata_i - DW'(STEP) : rf_rdata_i;

  rl_addr #(.AW(DW), .STEP(STEP)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_q == ST_BASE),
    .load_val_i(start_addr),
    .step_i    (hand),
    .down_i    (is_push),
    .addr_o    (addr_q),
    .addr_up_o (addr_up)
  );

  always_comb begin
    if (pick_idx == PICK_W'(LIST_W)) slot_reg = is_push ? IDX_LR : IDX_PC;
    else                             slot_reg = RIDX_W'(pick_idx);
  end

  assign xfer_act = (state_q == ST_XFER) && pick_vld;
  assign hand     = xfer_act && mem_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_valid_i) state_d = ST_BASE;
      ST_BASE: state_d = ST_XFER;
      ST_XFER: if (!pick_vld) state_d = ST_WB;
      ST_WB:   state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_LDM;
      base_q     <= '0;
      pend_q     <= '0;
      base_hit_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cmd_valid_i) begin
        op_q       <= rl_op_e'(cmd_op_i);
        base_q     <= stack_op ? IDX_SP : RIDX_W'(cmd_base_i);
        pend_q     <= {cmd_extra_i && stack_op, cmd_list_i};
        base_hit_q <= cmd_list_i[cmd_base_i];
        cnt_q      <= '0;
      end else if (hand) begin
        pend_q <= pend_q & ~(SLOT_N'(1) << pick_idx);
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign xfer_count_o = cnt_q;

  assign mem_addr_o  = addr_q;
  assign mem_rd_o    = xfer_act && is_load;
  assign mem_wr_o    = xfer_act && !is_load;
  assign mem_wdata_o = mem_wr_o ? rf_rdata_i : '0;

  assign rf_raddr_o = (state_q == ST_BASE) ? base_q : slot_reg;
  assign rf_we_o    = hand && is_load;
  assign rf_waddr_o = slot_reg;
  assign pc_load_o  = rf_we_o && (slot_reg == IDX_PC);
  assign rf_wdata_o = (slot_reg == IDX_PC) ? {mem_rdata_i[DW-1:1], 1'b0} : mem_rdata_i;

  assign wb_we_o   = (state_q == ST_WB) && !(op_q == OP_LDM && base_hit_q);
  assign wb_addr_o = base_q;
  assign wb_data_o = is_push ? addr_up : addr_q;

  p_strobe_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_hold_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) && !mem_ready_i |=>
      (mem_rd_o || mem_wr_o) && $stable(mem_addr_o) && $stable(rf_raddr_o));

  p_done_after_wb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q == ST_WB));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_pc_even_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> rf_we_o && !rf_wdata_o[0] && op_q == OP_POP);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o && !mem_wr_o && !wb_we_o);

  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SLOT_N));

  p_busy_ignores_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(op_q) && $stable(base_q));
endmodule

// File: tb/rl_seq_test.sv
`timescale 1ns/1ps
module rl_seq_test;
  typedef struct packed {
    logic [1:0] op;
    logic [2:0] base;
    logic [7:0] bval;
    logic [7:0] list;
    logic       extra;
    logic [1:0] stall;
    logic [3:0] cnt;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd2, 8'h20, 8'h0B, 1'b0, 2'd0, 4'd3},
    '{2'd0, 3'd1, 8'h40, 8'h82, 1'b0, 2'd1, 4'd2},
    '{2'd1, 3'd0, 8'h60, 8'hF1, 1'b0, 2'd2, 4'd5},
    '{2'd1, 3'd7, 8'h10, 8'h0E, 1'b0, 2'd0, 4'd3},
    '{2'd2, 3'd0, 8'hC0, 8'h81, 1'b1, 2'd1, 4'd3},
    '{2'd2, 3'd0, 8'h90, 8'h3C, 1'b0, 2'd0, 4'd4},
    '{2'd3, 3'd0, 8'hB4, 8'h81, 1'b1, 2'd0, 4'd3},
    '{2'd3, 3'd0, 8'h30, 8'h06, 1'b0, 2'd2, 4'd2},
    '{2'd0, 3'd3, 8'h00, 8'hFF, 1'b0, 2'd0, 4'd8},
    '{2'd3, 3'd0, 8'h44, 8'h00, 1'b1, 2'd1, 4'd1},
    '{2'd2, 3'd0, 8'h50, 8'h00, 1'b1, 2'd0, 4'd1},
    '{2'd1, 3'd5, 8'h24, 8'h00, 1'b0, 2'd0, 4'd0},
    '{2'd1, 3'd2, 8'h58, 8'h01, 1'b1, 2'd1, 4'd1}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_base;
  logic [7:0]  cmd_list;
  logic        cmd_extra;
  logic        busy, done;
  logic [3:0]  xcnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_ready;
  logic [3:0]  rf_raddr, rf_waddr, wb_addr;
  logic [31:0] rf_rdata, rf_wdata, wb_data;
  logic        rf_we, pc_load, wb_we;

  logic [31:0] rf  [16];
  logic [31:0] mem [64];
  logic [31:0] ref_rf  [16];
  logic [31:0] ref_mem [64];
  logic [31:0] acc_log [1024];
  logic [31:0] exp_acc [16];
  int exp_n, exp_pcl;

  logic        set_en;
  logic [3:0]  set_idx;
  logic [31:0] set_val;
  int stall_n, stall_ctr;
  int n_hand = 0, n_strobe = 0, n_pcl = 0, n_both = 0;
  int total = 0, bad = 0;
  logic strobe;

  rl_seq uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_base_i(cmd_base),
    .cmd_list_i(cmd_list), .cmd_extra_i(cmd_extra),
    .busy_o(busy), .done_o(done), .xfer_count_o(xcnt),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .pc_load_o(pc_load),
    .wb_we_o(wb_we), .wb_addr_o(wb_addr), .wb_data_o(wb_data)
  );

  assign strobe    = mem_rd || mem_wr;
  assign mem_ready = strobe && (stall_ctr >= stall_n);
  assign mem_rdata = mem[mem_addr[7:2]];
  assign rf_rdata  = rf[rf_raddr];

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) rf[i] <= 32'h1111_0000 + 32'(i) * 32'h101;
      for (int w = 0; w < 64; w++) mem[w] <= 32'hC0DE_0001 + (32'(w) << 4);
      stall_ctr <= 0;
    end else begin
      if (set_en) rf[set_idx] <= set_val;
      if (rf_we)  rf[rf_waddr] <= rf_wdata;
      if (wb_we)  rf[wb_addr] <= wb_data;
      if (mem_wr && mem_ready) mem[mem_addr[7:2]] <= mem_wdata;
      if (strobe) begin
        stall_ctr <= mem_ready ? 0 : stall_ctr + 1;
        n_strobe  <= n_strobe + 1;
      end
      if (mem_ready) begin
        acc_log[n_hand & 1023] <= mem_addr;
        n_hand <= n_hand + 1;
      end
      if (pc_load) n_pcl <= n_pcl + 1;
      if (mem_rd && mem_wr) n_both <= n_both + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic setreg(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    set_en = 1'b1; set_idx = idx; set_val = val;
    @(negedge clk);
    set_en = 1'b0;
    ref_rf[idx] = val;
  endtask

  // reference behaviour written from the requirements
  task automatic model(input vec_t v);
    logic [31:0] a;
    exp_n = 0; exp_pcl = 0;
    case (v.op)
      2'd0: begin
        a = ref_rf[v.base];
        for (int i = 0; i < 8; i++) if (v.list[i]) begin
          ref_rf[i] = ref_mem[a[7:2]]; exp_acc[exp_n] = a; exp_n++; a += 4;
        end
        if (!v.list[v.base]) ref_rf[v.base] = a;
      end
      2'd1: begin
        a = ref_rf[v.base];
        for (int i = 0; i < 8; i++) if (v.list[i]) begin
          ref_mem[a[7:2]] = ref_rf[i]; exp_acc[exp_n] = a; exp_n++; a += 4;
        end
        ref_rf[v.base] = a;
      end
      2'd2: begin
        a = ref_rf[13] - 4;
        if (v.extra) begin
          ref_mem[a[7:2]] = ref_rf[14]; exp_acc[exp_n] = a; exp_n++; a -= 4;
        end
        for (int i = 7; i >= 0; i--) if (v.list[i]) begin
          ref_mem[a[7:2]] = ref_rf[i]; exp_acc[exp_n] = a; exp_n++; a -= 4;
        end
        ref_rf[13] = a + 4;
      end
      default: begin
        a = ref_rf[13];
        for (int i = 0; i < 8; i++) if (v.list[i]) begin
          ref_rf[i] = ref_mem[a[7:2]]; exp_acc[exp_n] = a; exp_n++; a += 4;
        end
        if (v.extra) begin
          ref_rf[15] = ref_mem[a[7:2]] & 32'hFFFF_FFFE; exp_acc[exp_n] = a; exp_n++;
          exp_pcl = 1; a += 4;
        end
        ref_rf[13] = a;
      end
    endcase
  endtask

  task automatic run(input vec_t v, input bit poke, input string force_tag);
    string tseq, tst;
    int h0, s0, p0, cyc, wb_cyc, dn_cyc, seq_bad, rf_bad, mem_bad;
    bit exp_wb;
    case (v.op)
      2'd0: begin tseq = "R1"; tst = "R2"; end
      2'd1: begin tseq = "R3"; tst = "R3"; end
      2'd2: begin tseq = "R4"; tst = "R5"; end
      default: begin tseq = "R6"; tst = "R6"; end
    endcase
    if (force_tag != "") begin tseq = force_tag; tst = force_tag; end
    setreg((v.op >= 2'd2) ? 4'd13 : {1'b0, v.base}, {24'h0, v.bval});
    stall_n = int'(v.stall);
    exp_wb = !(v.op == 2'd0 && v.list[v.base]);
    model(v);
    h0 = n_hand; s0 = n_strobe; p0 = n_pcl;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = v.op; cmd_base = v.base; cmd_list = v.list; cmd_extra = v.extra;
    @(negedge clk);
    cmd_valid = 1'b0;
    wb_cyc = -1; dn_cyc = -1; cyc = 0;
    while (dn_cyc < 0 && cyc < 400) begin
      if (poke && cyc == 1) begin
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_base = 3'd6; cmd_list = 8'hFF;
      end
      @(negedge clk);
      cyc++;
      cmd_valid = 1'b0;
      if (wb_we) wb_cyc = cyc;
      if (done) dn_cyc = cyc;
    end
    chk(dn_cyc > 0, "R9", "done seen", 32'(dn_cyc), 32'(1));
    if (exp_wb) chk(dn_cyc == wb_cyc + 1, "R9", "done one cycle after writeback", 32'(dn_cyc), 32'(wb_cyc + 1));
    else chk(wb_cyc < 0, "R2", "no writeback with base in list", 32'(wb_cyc), 32'hFFFF_FFFF);
    @(negedge clk);
    chk(!done && !busy, "R9", "done single pulse", {30'h0, done, busy}, 32'h0);
    // sequence of accessed addresses
    seq_bad = (n_hand - h0 != exp_n) ? 1 : 0;
    for (int k = 0; k < exp_n && seq_bad == 0; k++)
      if (acc_log[(h0 + k) & 1023] !== exp_acc[k]) seq_bad = 1;
    chk(seq_bad == 0, tseq, "address order", acc_log[h0 & 1023], exp_acc[0]);
    rf_bad = -1;
    for (int i = 0; i < 16; i++) if (rf_bad < 0 && rf[i] !== ref_rf[i]) rf_bad = i;
    chk(rf_bad < 0, tst, "register file", (rf_bad < 0) ? 32'h0 : rf[rf_bad],
        (rf_bad < 0) ? 32'h0 : ref_rf[rf_bad]);
    mem_bad = -1;
    for (int w = 0; w < 64; w++) if (mem_bad < 0 && mem[w] !== ref_mem[w]) mem_bad = w;
    chk(mem_bad < 0, (v.op == 2'd2) ? "R4" : "R12", "memory", (mem_bad < 0) ? 32'h0 : mem[mem_bad],
        (mem_bad < 0) ? 32'h0 : ref_mem[mem_bad]);
    chk(xcnt == v.cnt && exp_n == int'(v.cnt), "R7", "transfer count", {28'h0, xcnt}, {28'h0, v.cnt});
    chk(n_strobe - s0 == exp_n * (stall_n + 1), (exp_n == 0) ? "R10" : "R8", "strobe cycles",
        32'(n_strobe - s0), 32'(exp_n * (stall_n + 1)));
    chk(n_pcl - p0 == exp_pcl, "R6", "pc load strobes", 32'(n_pcl - p0), 32'(exp_pcl));
  endtask

  bit finished = 1'b0;

  initial begin
    #750000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t e;
    rst_ni = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_base = '0; cmd_list = '0; cmd_extra = 1'b0;
    set_en = 1'b0; set_idx = '0; set_val = '0; stall_n = 0;
    for (int i = 0; i < 16; i++) ref_rf[i] = 32'h1111_0000 + 32'(i) * 32'h101;
    for (int w = 0; w < 64; w++) ref_mem[w] = 32'hC0DE_0001 + (32'(w) << 4);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr && xcnt == 0, "R13", "reset state",
        {27'h0, busy, done, mem_rd, mem_wr, |xcnt}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wb_we && !rf_we, "R13", "idle after reset",
        {28'h0, busy, done, wb_we, rf_we}, 32'h0);

    for (int k = 0; k < NV; k++) run(VEC[k], 1'b0, "");

    // request while busy must be dropped
    e = '{2'd0, 3'd4, 8'h28, 8'h31, 1'b0, 2'd2, 4'd3};
    run(e, 1'b1, "R11");
    repeat (3) @(negedge clk);
    chk(!busy, "R11", "no hidden second command", {31'h0, busy}, 32'h0);

    // empty push and pop: no access, stack pointer unchanged
    e = '{2'd2, 3'd0, 8'h70, 8'h00, 1'b0, 2'd0, 4'd0};
    run(e, 1'b0, "R10");
    e = '{2'd3, 3'd0, 8'h3C, 8'h00, 1'b0, 2'd0, 4'd0};
    run(e, 1'b0, "R10");
    chk(n_both == 0, "R12", "read and write strobes together", 32'(n_both), 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule